// File: doc/BRIEF.md
# Two-Byte I2C Control Register Slave

This block is an I2C slave that sits behind two pad inputs, SCL and SDA, and keeps a small control register for a linear current driver. It samples both lines on the system clock and recognises start and stop conditions. It answers one 7-bit device address, chosen by a two-bit strap from four values. A write carries a most-significant byte and then a least-significant byte. Together these give a 10-bit current level, a 4-bit ramp timing code and a sleep request.

The outputs and a one-cycle strobe change only when the second byte has been acknowledged. A read returns the two bytes most recently written, most-significant byte first. A start or stop seen at any point restarts the transfer logic. An open-drain pad is modelled by a single pull-low output. Clock stretching is not supported.

Top module: `lvl_i2c_slave`

## Requirements
- R1: After a synchronous reset, dac_level, ramp_code and sleep_mode are 0, wr_done is low, sda_pull is low, and a read returns 0x00 for both bytes.
- R2: The device address is {0b0011, addr_sel[1:0], 0b0} (0x18, 0x1A, 0x1C or 0x1E). On a match the slave pulls SDA low for the ninth clock of the address byte. Any other address gets no acknowledge, and the slave ignores every following byte until the next start.
- R3: Field mapping. In the first data byte, bit 7 drives sleep_mode (1 = sleep), bit 6 is stored but drives no output, and bits 5..0 become dac_level[9:4]. In the second byte, bits 7..4 become dac_level[3:0] and bits 3..0 become ramp_code[3:0], with bit 3 the highest.
- R4: During a write, every data byte received after a matched address is acknowledged by pulling SDA low on its ninth clock.
- R5: dac_level, ramp_code and sleep_mode update only when the ninth clock of the second data byte ends. wr_done pulses high for exactly one clock for each completed two-byte write.
- R6: A write cut short by a stop or a start before the second byte's acknowledge leaves dac_level, ramp_code and sleep_mode unchanged and produces no wr_done pulse.
- R7: A start that appears inside any byte, including the address byte, discards the partial byte and begins a new address phase. A complete write that follows it takes effect normally.
- R8: A read (R/W bit 1) returns the last written first byte and then the last written second byte, each MSB first. Bit 6 is returned as it was written.
- R9: When the master NACKs a read byte, the slave releases SDA and keeps sda_pull low for any further clocks until a stop or start. A stop always releases SDA.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_sel | input | 2 | Address strap, selects device address bits 2..1 |
| scl_in | input | 1 | Serial clock line as seen at the pad |
| sda_in | input | 1 | Serial data line as seen at the pad |
| sda_pull | output | 1 | 1 = pull SDA low (acknowledge or read data 0) |
| dac_level | output | 10 | Programmed current level code |
| ramp_code | output | 4 | Programmed ramp timing code |
| sleep_mode | output | 1 | Sleep request, 1 = sleep |
| wr_done | output | 1 | One-cycle strobe when a two-byte write completes |

## Verification
The bench builds the block with its default parameters: a two-stage line synchroniser, a 10-bit level and a 4-bit ramp code. With these the field split falls at bits 5..0 of the first byte and bits 7..4 of the second. SCL runs at 100 system clocks per bit, so the three-cycle sampling delay sits well inside each low phase. The bench can then observe the acknowledge and read-data timing on a wired-AND bus model. Every address strap value is exercised, as are the bit patterns that cross the byte boundary of the level field. The corner cases covered are aborted writes, a restart inside the address byte and a NACK-terminated read.

// File: rtl/lvl_i2c_pkg.sv
package lvl_i2c_pkg;
  localparam int BYTE_W = 8;
  localparam logic [3:0] ADDR_HI = 4'b0011;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK_A,
    ST_WR,
    ST_ACK_W,
    ST_RD,
    ST_RD_ACK,
    ST_WAIT
  } slv_state_t;
endpackage

// File: rtl/i2c_line_sampler.sv
module i2c_line_sampler #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [1:0] raw;
  logic [1:0] synced;
  logic       scl_q, sda_q;

  assign raw = {scl_in, sda_in};

  for (genvar g = 0; g < 2; g++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= '1;
      else     chain <= {chain[STAGES-2:0], raw[g]};
    end
    assign synced[g] = chain[STAGES-1];
  end

  assign scl_s = synced[1];
  assign sda_s = synced[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_xfer_seq.sv
module i2c_xfer_seq
  import lvl_i2c_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        addr_sel,
  input  logic              scl_s,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [BYTE_W-1:0] rd_first,
  input  logic [BYTE_W-1:0] rd_second,
  output logic              sda_pull,
  output logic              commit,
  output logic [BYTE_W-1:0] wr_first,
  output logic [BYTE_W-1:0] wr_second
);
  localparam logic [3:0] BITS_DONE = 4'(BYTE_W);

  slv_state_t        state;
  logic [3:0]        cnt;
  logic [BYTE_W-1:0] shreg;
  logic [BYTE_W-1:0] first_hold;
  logic [BYTE_W-1:0] tx;
  logic              rw;
  logic              byte_idx;
  logic              ack_seen;
  logic [6:0]        my_addr;
  logic [BYTE_W-1:0] nxt_byte;

  assign my_addr  = {ADDR_HI, addr_sel, 1'b0};
  assign nxt_byte = byte_idx ? rd_first : rd_second;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      cnt        <= '0;
      shreg      <= '0;
      first_hold <= '0;
      tx         <= '0;
      rw         <= 1'b0;
      byte_idx   <= 1'b0;
      ack_seen   <= 1'b0;
      sda_pull   <= 1'b0;
      commit     <= 1'b0;
    end else begin
      commit <= 1'b0;
      if (start_det) begin
        state    <= ST_ADDR;
        cnt      <= '0;
        sda_pull <= 1'b0;
        byte_idx <= 1'b0;
        ack_seen <= 1'b0;
      end else if (stop_det) begin
        state    <= ST_IDLE;
        sda_pull <= 1'b0;
        byte_idx <= 1'b0;
        ack_seen <= 1'b0;
      end else begin
        case (state)
          ST_ADDR, ST_WR: begin
            if (scl_rise && cnt < BITS_DONE) begin
              shreg <= {shreg[BYTE_W-2:0], sda_s};
              cnt   <= cnt + 4'd1;
            end else if (scl_fall && cnt == BITS_DONE) begin
              if (state == ST_ADDR) begin
                if (shreg[BYTE_W-1:1] == my_addr) begin
                  sda_pull <= 1'b1;
                  rw       <= shreg[0];
                  state    <= ST_ACK_A;
                end else begin
                  state <= ST_WAIT;
                end
              end else begin
                sda_pull <= 1'b1;
                state    <= ST_ACK_W;
              end
            end
          end
          ST_ACK_A: begin
            if (scl_fall) begin
              cnt      <= '0;
              byte_idx <= 1'b0;
              if (rw) begin
                state    <= ST_RD;
                tx       <= rd_first;
                sda_pull <= ~rd_first[BYTE_W-1];
              end else begin
                state    <= ST_WR;
                sda_pull <= 1'b0;
              end
            end
          end
          ST_ACK_W: begin
            if (scl_fall) begin
              sda_pull <= 1'b0;
              cnt      <= '0;
              state    <= ST_WR;
              byte_idx <= ~byte_idx;
              if (byte_idx) commit     <= 1'b1;
              else          first_hold <= shreg;
            end
          end
          ST_RD: begin
            if (scl_rise) begin
              cnt <= cnt + 4'd1;
            end else if (scl_fall) begin
              if (cnt == BITS_DONE) begin
                sda_pull <= 1'b0;
                state    <= ST_RD_ACK;
              end else begin
                sda_pull <= ~tx[BYTE_W-2];
                tx       <= {tx[BYTE_W-2:0], 1'b0};
              end
            end
          end
          ST_RD_ACK: begin
            if (scl_rise) begin
              if (sda_s) state    <= ST_WAIT;
              else       ack_seen <= 1'b1;
            end else if (scl_fall && ack_seen) begin
              ack_seen <= 1'b0;
              byte_idx <= ~byte_idx;
              tx       <= nxt_byte;
              sda_pull <= ~nxt_byte[BYTE_W-1];
              cnt      <= '0;
              state    <= ST_RD;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign wr_first  = first_hold;
  assign wr_second = shreg;

  // R2: the slave only starts pulling SDA while the sampled clock is low
  assert_drive_low_scl_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_pull) |-> !scl_s);

  // R9: a stop always lets go of SDA
  assert_stop_release_R9: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> !sda_pull);

  // R7: a start restarts the address phase from bit zero
  assert_start_resets_R7: assert property (@(posedge clk) disable iff (rst)
    start_det |=> (state == ST_ADDR && cnt == 4'd0 && !sda_pull));
endmodule

// File: rtl/ctrl_reg_store.sv
module ctrl_reg_store
  import lvl_i2c_pkg::*;
#(
  parameter int DAC_W  = 10,
  parameter int RAMP_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              commit,
  input  logic [BYTE_W-1:0] wr_first,
  input  logic [BYTE_W-1:0] wr_second,
  output logic [BYTE_W-1:0] first_q,
  output logic [BYTE_W-1:0] second_q,
  output logic [DAC_W-1:0]  dac_level,
  output logic [RAMP_W-1:0] ramp_code,
  output logic              sleep_mode,
  output logic              wr_done
);
  localparam int LO_DAC = BYTE_W - RAMP_W;
  localparam int HI_DAC = DAC_W - LO_DAC;

  always_ff @(posedge clk) begin
    if (rst) begin
      first_q    <= '0;
      second_q   <= '0;
      dac_level  <= '0;
      ramp_code  <= '0;
      sleep_mode <= 1'b0;
      wr_done    <= 1'b0;
    end else begin
      wr_done <= commit;
      if (commit) begin
        first_q    <= wr_first;
        second_q   <= wr_second;
        dac_level  <= {wr_first[HI_DAC-1:0], wr_second[BYTE_W-1:RAMP_W]};
        ramp_code  <= wr_second[RAMP_W-1:0];
        sleep_mode <= wr_first[BYTE_W-1];
      end
    end
  end

  // R5: the completion strobe lasts one cycle
  assert_strobe_single_R5: assert property (@(posedge clk) disable iff (rst)
    wr_done |=> !wr_done);

  // R6: without a commit the programmed fields hold
  assert_hold_fields_R6: assert property (@(posedge clk) disable iff (rst)
    !commit |=> ($stable(dac_level) && $stable(ramp_code) && $stable(sleep_mode)));
endmodule

// File: rtl/lvl_i2c_slave.sv
module lvl_i2c_slave
  import lvl_i2c_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DAC_W       = 10,
  parameter int RAMP_W      = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        addr_sel,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              sda_pull,
  output logic [DAC_W-1:0]  dac_level,
  output logic [RAMP_W-1:0] ramp_code,
  output logic              sleep_mode,
  output logic              wr_done
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic commit;
  logic [BYTE_W-1:0] wr_first, wr_second, first_q, second_q;

  i2c_line_sampler #(.STAGES(SYNC_STAGES)) u_sampler (
    .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_xfer_seq u_seq (
    .clk(clk), .rst(rst), .addr_sel(addr_sel),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det),
    .rd_first(first_q), .rd_second(second_q),
    .sda_pull(sda_pull), .commit(commit),
    .wr_first(wr_first), .wr_second(wr_second)
  );

  ctrl_reg_store #(.DAC_W(DAC_W), .RAMP_W(RAMP_W)) u_store (
    .clk(clk), .rst(rst), .commit(commit),
    .wr_first(wr_first), .wr_second(wr_second),
    .first_q(first_q), .second_q(second_q),
    .dac_level(dac_level), .ramp_code(ramp_code),
    .sleep_mode(sleep_mode), .wr_done(wr_done)
  );
endmodule

// File: tb/tb_lvl_i2c_slave.sv
module tb_lvl_i2c_slave;
  localparam int Q = 25;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] addr_sel = 2'd0;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic       sda_line;
  logic       sda_pull;
  logic [9:0] dac_level;
  logic [3:0] ramp_code;
  logic       sleep_mode;
  logic       wr_done;

  int checks = 0;
  int errors = 0;
  int done_cnt = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  assign sda_line = sda_m & ~sda_pull;

  lvl_i2c_slave dut (
    .clk(clk), .rst(rst), .addr_sel(addr_sel),
    .scl_in(scl_m), .sda_in(sda_line), .sda_pull(sda_pull),
    .dac_level(dac_level), .ramp_code(ramp_code),
    .sleep_mode(sleep_mode), .wr_done(wr_done)
  );

  always @(posedge clk) if (!rst && wr_done) done_cnt++;

  // {addr_sel, first, second, dac, ramp, sleep}
  localparam logic [32:0] VEC [4] = '{
    {2'd0, 8'hBF, 8'hA5, 10'h3FA, 4'h5, 1'b1},
    {2'd1, 8'h01, 8'h0F, 10'h010, 4'hF, 1'b0},
    {2'd2, 8'h40, 8'hF0, 10'h00F, 4'h0, 1'b0},
    {2'd3, 8'h2A, 8'h53, 10'h2A5, 4'h3, 1'b0}
  };

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic i2c_start;
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic i2c_stop;
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b1; tick(2*Q);
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; tick(Q);
    scl_m = 1'b1; tick(2*Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int k = 7; k >= 0; k--) send_bit(b[k]);
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    ack = ~sda_line; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic recv_byte(input logic master_ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int k = 7; k >= 0; k--) begin
      tick(Q);
      scl_m = 1'b1; tick(Q);
      b[k] = sda_line; tick(Q);
      scl_m = 1'b0;
    end
    tick(Q);
    sda_m = ~master_ack; tick(Q);
    scl_m = 1'b1; tick(2*Q);
    scl_m = 1'b0; tick(Q);
    sda_m = 1'b1;
  endtask

  function automatic logic [7:0] dev(input logic [1:0] sel, input logic rd);
    return {4'b0011, sel, 1'b0, rd};
  endfunction

  task automatic check_fields(input string req, input logic [9:0] d, input logic [3:0] r, input logic s);
    tick(1);
    @(negedge clk);
    chk({req, " dac"}, 32'(dac_level), 32'(d));
    chk({req, " ramp"}, 32'(ramp_code), 32'(r));
    chk({req, " sleep"}, 32'(sleep_mode), 32'(s));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic a0, a1, a2;
    logic [7:0] rb0, rb1;
    int base;

    tick(6);
    @(negedge clk);
    chk("R1 dac after reset", 32'(dac_level), 0);
    chk("R1 ramp after reset", 32'(ramp_code), 0);
    chk("R1 sleep after reset", 32'(sleep_mode), 0);
    chk("R1 strobe after reset", 32'(wr_done), 0);
    chk("R1 sda after reset", 32'(sda_pull), 0);
    rst = 1'b0;
    tick(4);

    // R1: read of the reset contents
    i2c_start;
    send_byte(dev(2'd0, 1'b1), a0);
    recv_byte(1'b1, rb0);
    recv_byte(1'b0, rb1);
    i2c_stop;
    chk("R1 read first byte", 32'(rb0), 0);
    chk("R1 read second byte", 32'(rb1), 0);

    for (int i = 0; i < 4; i++) begin
      logic [32:0] v;
      v = VEC[i];
      addr_sel = v[32:31];
      base = done_cnt;
      i2c_start;
      send_byte(dev(v[32:31], 1'b0), a0);
      send_byte(v[30:23], a1);
      send_byte(v[22:15], a2);
      i2c_stop;
      chk("R2 write address ack", 32'(a0), 1);
      chk("R4 first byte ack", 32'(a1), 1);
      chk("R4 second byte ack", 32'(a2), 1);
      check_fields("R3", v[14:5], v[4:1], v[0]);
      chk("R5 one strobe per write", 32'(done_cnt - base), 1);

      i2c_start;
      send_byte(dev(v[32:31], 1'b1), a0);
      recv_byte(1'b1, rb0);
      recv_byte(1'b0, rb1);
      chk("R9 released after nack", 32'(sda_pull), 0);
      i2c_stop;
      chk("R2 read address ack", 32'(a0), 1);
      chk("R8 read first byte", 32'(rb0), 32'(v[30:23]));
      chk("R8 read second byte", 32'(rb1), 32'(v[22:15]));
    end

    // R2: foreign address is not acked and its data is ignored
    base = done_cnt;
    i2c_start;
    send_byte(dev(2'd0, 1'b0), a0);
    send_byte(8'hFF, a1);
    send_byte(8'hFF, a2);
    i2c_stop;
    chk("R2 foreign address nack", 32'(a0), 0);
    chk("R2 foreign data nack", 32'(a1 | a2), 0);
    check_fields("R2 ignored", 10'h2A5, 4'h3, 1'b0);
    chk("R2 no strobe", 32'(done_cnt - base), 0);

    // R6: stop after the first byte
    i2c_start;
    send_byte(dev(2'd3, 1'b0), a0);
    send_byte(8'h81, a1);
    i2c_stop;
    check_fields("R6 stop abort", 10'h2A5, 4'h3, 1'b0);
    chk("R6 no strobe on stop abort", 32'(done_cnt - base), 0);

    // R7: restart inside the address byte, then a full write
    i2c_start;
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
    i2c_start;
    send_byte(dev(2'd3, 1'b0), a0);
    send_byte(8'h00, a1);
    send_byte(8'h1C, a2);
    i2c_stop;
    chk("R7 ack after restart", 32'(a0 & a1 & a2), 1);
    check_fields("R7 write after restart", 10'h001, 4'hC, 1'b0);
    chk("R7 one strobe", 32'(done_cnt - base), 1);

    // R6/R7: restart inside the second byte, then stop
    base = done_cnt;
    i2c_start;
    send_byte(dev(2'd3, 1'b0), a0);
    send_byte(8'hFF, a1);
    send_bit(1'b1); send_bit(1'b1); send_bit(1'b1);
    i2c_start;
    i2c_stop;
    check_fields("R6 restart abort", 10'h001, 4'hC, 1'b0);
    chk("R6 no strobe on restart abort", 32'(done_cnt - base), 0);

    // R9: NACK on first read byte, extra clocks see no drive
    i2c_start;
    send_byte(dev(2'd3, 1'b1), a0);
    recv_byte(1'b0, rb0);
    chk("R8 read after restart write", 32'(rb0), 32'h00);
    chk("R9 released after first nack", 32'(sda_pull), 0);
    begin
      int drove;
      drove = 0;
      for (int k = 0; k < 9; k++) begin
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        if (sda_pull) drove++;
        tick(Q);
        scl_m = 1'b0; tick(Q);
      end
      chk("R9 silent until stop", 32'(drove), 0);
    end
    i2c_stop;

    // R1: reset again clears programmed fields
    rst = 1'b1;
    tick(3);
    @(negedge clk);
    chk("R1 dac after second reset", 32'(dac_level), 0);
    chk("R1 ramp after second reset", 32'(ramp_code), 0);
    rst = 1'b0;

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule